// File: doc/BRIEF.md
# Software Reset Controller with Legacy Mirror

This block lets software hold peripherals in reset through two register views of the same reset bits. The first view is one 32-bit legacy word that covers the serial ports, synchronous serial ports, quadrature decoders, I2C controllers, timers and comparators at fixed bit positions. The second view is one register per peripheral class, with one bit per instance. A write to the legacy word is first gated by a capability mask input. The result is then written into the matching bits of the class registers. A write to a class register never changes the legacy word.

Each reset output is a level signal taken from the class registers. The comparator module has a single reset output. It is asserted when its one-bit class register is set, or when any of the three comparator bits in the legacy word is set. Class registers can hold more instances than the legacy word covers. Those extra instances can only be reset through their class register.

Top module: `swResetCtl`

## Requirements
- R1: The legacy word (address 0) decodes serial ports 0..2 at bits 0..2, synchronous serial 0..1 at bits 4..5, decoders 0..1 at bits 8..9, I2C 0 at bit 12 and I2C 1 at bit 14. It decodes timers 0..3 at bits 16..19 and comparators 0..2 at bits 24..26. Every other bit reads as 0, whatever was written to it.
- R2: While `rstN` is low, every register and every reset output is 0. After `rstN` is released, every address reads 0 until the first write.
- R3: A legacy write stores `busWdata & capMask` restricted to the R1 bits. A later read of address 0 returns exactly that value.
- R4: A legacy write also overwrites, in both directions, each legacy-covered instance bit in the class registers. This covers class instance i of the serial, synchronous serial, decoder, I2C (from bit 12+2i) and timer classes. The comparator class bit is set to the OR of the three stored comparator bits.
- R5: Writing a class register (address 1 serial, 2 synchronous serial, 3 decoder, 4 I2C, 5 timer, 6 comparator) stores its low bits, one per instance, with no capability gating. It leaves the legacy word unchanged. Bits at or above the instance count read as 0.
- R6: `rstComp` is 1 when the comparator class bit (address 6, bit 0) is 1, or when any legacy comparator bit is 1.
- R7: With no write, every register and every reset output holds its value indefinitely. Nothing clears itself.
- R8: A write captured at clock edge k changes the reset outputs at edge k+1, not at edge k.
- R9: A read returns data at the clock edge that samples the address. Addresses 7 and above read 0, and writes to them change nothing.
- R10: Class instances beyond the legacy coverage (serial 3 and up, timer 4 and up) are controlled only by their class register. Legacy writes never touch them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busWe | input | 1 | Write enable for the current bus cycle |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| capMask | input | 32 | Capability mask applied to legacy writes |
| busRdata | output | 32 | Registered read data |
| rstUart | output | NUM_UART | Serial port reset levels |
| rstSsi | output | NUM_SSI | Synchronous serial reset levels |
| rstQei | output | NUM_QEI | Quadrature decoder reset levels |
| rstI2c | output | NUM_I2C | I2C controller reset levels |
| rstTimer | output | NUM_TIMER | Timer reset levels |
| rstComp | output | 1 | Merged comparator module reset level |

## Verification
The bench builds the block with five serial ports and six timers. This gives each of those classes instances beyond the legacy word's coverage, so the rule that legacy writes leave those instances alone can be observed at the outputs. The other classes keep their default counts, which match the legacy coverage exactly, so every legacy bit has a real instance behind it. Random capability masks then exercise partial gating across all mirrored fields.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int NUM_CLASSES = 6;
  localparam int CLS_UART  = 0;
  localparam int CLS_SSI   = 1;
  localparam int CLS_QEI   = 2;
  localparam int CLS_I2C   = 3;
  localparam int CLS_TIMER = 4;
  localparam int CLS_COMP  = 5;

  typedef struct packed {
    logic                   wrLegacy;
    logic [NUM_CLASSES-1:0] wrClass;
    logic                   rdHit;
    logic [2:0]             rdSel;
  } swrstStrobes_t;
endpackage

// File: rtl/swrstCtrl.sv
module swrstCtrl
  import swrst_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output swrstStrobes_t     strb
);
  localparam int LEGACY_ADDR = 0;
  localparam int CLASS_BASE  = 1;

  always_comb begin
    strb = '0;
    if (busAddr == ADDR_W'(LEGACY_ADDR)) begin
      strb.rdHit    = 1'b1;
      strb.rdSel    = 3'd0;
      strb.wrLegacy = busWe;
    end
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (busAddr == ADDR_W'(CLASS_BASE + c)) begin
        strb.rdHit      = 1'b1;
        strb.rdSel      = 3'(CLASS_BASE + c);
        strb.wrClass[c] = busWe;
      end
    end
  end
endmodule

// File: rtl/swrstDatapath.sv
module swrstDatapath
  import swrst_pkg::*;
#(
  parameter int NUM_UART  = 3,
  parameter int NUM_SSI   = 2,
  parameter int NUM_QEI   = 2,
  parameter int NUM_I2C   = 2,
  parameter int NUM_TIMER = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swrstStrobes_t        strb,
  input  logic [31:0]          busWdata,
  input  logic [31:0]          capMask,
  output logic [31:0]          busRdata,
  output logic [NUM_UART-1:0]  rstUart,
  output logic [NUM_SSI-1:0]   rstSsi,
  output logic [NUM_QEI-1:0]   rstQei,
  output logic [NUM_I2C-1:0]   rstI2c,
  output logic [NUM_TIMER-1:0] rstTimer,
  output logic                 rstComp
);
  localparam int COMP_LSB  = 24;
  localparam int COMP_LEG  = 3;
  localparam int PER_CLASS = 5;

  function automatic int legCount(int c);
    case (c)
      CLS_UART:  return 3;
      CLS_TIMER: return 4;
      default:   return 2;
    endcase
  endfunction

  function automatic int instCount(int c);
    case (c)
      CLS_UART:  return NUM_UART;
      CLS_SSI:   return NUM_SSI;
      CLS_QEI:   return NUM_QEI;
      CLS_I2C:   return NUM_I2C;
      default:   return NUM_TIMER;
    endcase
  endfunction

  function automatic int legPos(int c, int i);
    case (c)
      CLS_UART:  return i;
      CLS_SSI:   return 4 + i;
      CLS_QEI:   return 8 + i;
      CLS_I2C:   return 12 + 2 * i;
      default:   return 16 + i;
    endcase
  endfunction

  function automatic logic [31:0] buildValid();
    logic [31:0] v = '0;
    for (int c = 0; c < PER_CLASS; c++)
      for (int i = 0; i < legCount(c); i++) v[legPos(c, i)] = 1'b1;
    for (int k = 0; k < COMP_LEG; k++) v[COMP_LSB + k] = 1'b1;
    return v;
  endfunction

  localparam logic [31:0] LEG_VALID = buildValid();

  logic [31:0]                legacyQ;
  logic [31:0]                legNext;
  logic [PER_CLASS-1:0][31:0] classQ;
  logic                       compQ;
  logic [31:0]                rdNext;
  logic                       legCompAny;

  assign legNext    = busWdata & capMask & LEG_VALID;
  assign legCompAny = |legacyQ[COMP_LSB +: COMP_LEG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              legacyQ <= '0;
    else if (strb.wrLegacy) legacyQ <= legNext;
  end

  for (genvar c = 0; c < PER_CLASS; c++) begin : g_cls
    localparam int W = instCount(c);
    localparam int M = (W < legCount(c)) ? W : legCount(c);
    localparam logic [31:0] WMASK = (W >= 32) ? '1 : ((32'd1 << W) - 32'd1);
    logic [31:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strb.wrClass[c]) q <= busWdata & WMASK;
      else if (strb.wrLegacy)
        for (int i = 0; i < M; i++) q[i] <= legNext[legPos(c, i)];
    end
    assign classQ[c] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     compQ <= 1'b0;
    else if (strb.wrClass[CLS_COMP]) compQ <= busWdata[0];
    else if (strb.wrLegacy)        compQ <= |legNext[COMP_LSB +: COMP_LEG];
  end

  always_comb begin
    case (strb.rdSel)
      3'd0:    rdNext = legacyQ;
      3'd1:    rdNext = classQ[CLS_UART];
      3'd2:    rdNext = classQ[CLS_SSI];
      3'd3:    rdNext = classQ[CLS_QEI];
      3'd4:    rdNext = classQ[CLS_I2C];
      3'd5:    rdNext = classQ[CLS_TIMER];
      3'd6:    rdNext = {31'd0, compQ};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      rstUart  <= '0;
      rstSsi   <= '0;
      rstQei   <= '0;
      rstI2c   <= '0;
      rstTimer <= '0;
      rstComp  <= 1'b0;
    end else begin
      busRdata <= strb.rdHit ? rdNext : '0;
      rstUart  <= classQ[CLS_UART][NUM_UART-1:0];
      rstSsi   <= classQ[CLS_SSI][NUM_SSI-1:0];
      rstQei   <= classQ[CLS_QEI][NUM_QEI-1:0];
      rstI2c   <= classQ[CLS_I2C][NUM_I2C-1:0];
      rstTimer <= classQ[CLS_TIMER][NUM_TIMER-1:0];
      rstComp  <= compQ | legCompAny;
    end
  end

  // R9: at most one register is targeted by any write
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLegacy, strb.wrClass}));

  // R5: class writes never reach the legacy word
  a_r5_legacy_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.wrClass && !strb.wrLegacy) |=> $stable(legacyQ));

  // R3: no legacy bit survives outside the capability mask
  a_r3_cap_gated: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLegacy |=> ((legacyQ & ~$past(capMask)) == 32'd0));

  // R4: serial port 0 follows the legacy word after a legacy write
  a_r4_write_through: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLegacy |=> (classQ[CLS_UART][0] == legacyQ[0]));

  // R6: either comparator source drives the merged reset
  a_r6_comp_merge: assert property (@(posedge clk) disable iff (!rstN)
    (compQ || legCompAny) |=> rstComp);

  // R7: no self clearing without a write
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrLegacy && strb.wrClass == '0) |=>
      ($stable(legacyQ) && $stable(classQ) && $stable(compQ)));

  // R8: outputs follow the register one edge later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(classQ[CLS_UART][0]) |=> rstUart[0]);
endmodule

// File: rtl/swResetCtl.sv
module swResetCtl
  import swrst_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_UART  = 3,
  parameter int NUM_SSI   = 2,
  parameter int NUM_QEI   = 2,
  parameter int NUM_I2C   = 2,
  parameter int NUM_TIMER = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  input  logic [31:0]          capMask,
  output logic [31:0]          busRdata,
  output logic [NUM_UART-1:0]  rstUart,
  output logic [NUM_SSI-1:0]   rstSsi,
  output logic [NUM_QEI-1:0]   rstQei,
  output logic [NUM_I2C-1:0]   rstI2c,
  output logic [NUM_TIMER-1:0] rstTimer,
  output logic                 rstComp
);
  swrstStrobes_t strb;

  swrstCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  swrstDatapath #(
    .NUM_UART (NUM_UART),
    .NUM_SSI  (NUM_SSI),
    .NUM_QEI  (NUM_QEI),
    .NUM_I2C  (NUM_I2C),
    .NUM_TIMER(NUM_TIMER)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .capMask (capMask),
    .busRdata(busRdata),
    .rstUart (rstUart),
    .rstSsi  (rstSsi),
    .rstQei  (rstQei),
    .rstI2c  (rstI2c),
    .rstTimer(rstTimer),
    .rstComp (rstComp)
  );
endmodule

// File: tb/test_swResetCtl.sv
module test_swResetCtl;
  localparam int NU = 5, NS = 2, NQ = 2, NI = 2, NT = 6;
  localparam logic [31:0] VALID = 32'h070F_5337;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] capMask = '1;
  logic [31:0] busRdata;
  logic [NU-1:0] rstUart;
  logic [NS-1:0] rstSsi;
  logic [NQ-1:0] rstQei;
  logic [NI-1:0] rstI2c;
  logic [NT-1:0] rstTimer;
  logic          rstComp;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [31:0] legM = '0, uM = '0, sM = '0, qM = '0, iM = '0, tM = '0;
  logic        cM = 1'b0;

  always #5 clk = ~clk;

  swResetCtl #(.ADDR_W(4), .NUM_UART(NU), .NUM_SSI(NS), .NUM_QEI(NQ),
               .NUM_I2C(NI), .NUM_TIMER(NT)) i_swResetCtl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .capMask(capMask), .busRdata(busRdata),
    .rstUart(rstUart), .rstSsi(rstSsi), .rstQei(rstQei), .rstI2c(rstI2c),
    .rstTimer(rstTimer), .rstComp(rstComp));

  function automatic logic [31:0] wmask(int n);
    return (32'd1 << n) - 32'd1;
  endfunction

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      4'd0: return legM;
      4'd1: return uM;
      4'd2: return sM;
      4'd3: return qM;
      4'd4: return iM;
      4'd5: return tM;
      4'd6: return {31'd0, cM};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic expComp();
    return cM | (|legM[26:24]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(logic [3:0] a, logic [31:0] d);
    logic [31:0] g;
    case (a)
      4'd0: begin
        g = d & capMask & VALID;
        legM = g;
        for (int i = 0; i < 3; i++) uM[i] = g[i];
        for (int i = 0; i < 2; i++) sM[i] = g[4+i];
        for (int i = 0; i < 2; i++) qM[i] = g[8+i];
        for (int i = 0; i < 2; i++) iM[i] = g[12+2*i];
        for (int i = 0; i < 4; i++) tM[i] = g[16+i];
        cM = |g[26:24];
      end
      4'd1: uM = d & wmask(NU);
      4'd2: sM = d & wmask(NS);
      4'd3: qM = d & wmask(NQ);
      4'd4: iM = d & wmask(NI);
      4'd5: tM = d & wmask(NT);
      4'd6: cM = d[0];
      default: ;
    endcase
  endtask

  // starts and ends just after a falling edge
  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(string req, logic [3:0] a);
    busAddr = a;
    @(negedge clk);
    chk(req, busRdata, expRead(a));
  endtask

  task automatic checkOuts(string req);
    chk({req, " uart"},  32'(rstUart),  uM);
    chk({req, " ssi"},   32'(rstSsi),   sM);
    chk({req, " qei"},   32'(rstQei),   qM);
    chk({req, " i2c"},   32'(rstI2c),   iM);
    chk({req, " timer"}, 32'(rstTimer), tM);
    chk({req, " comp"},  32'(rstComp),  32'(expComp()));
  endtask

  task automatic settle(string req);
    @(negedge clk);
    checkOuts(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkOuts("R2 in reset");
    chk("R2 rdata in reset", busRdata, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) busRead("R2 read after reset", 4'(a));

    // R1 and R3: full write, full capability
    capMask = '1;
    busWrite(4'd0, 32'hFFFF_FFFF);
    settle("R4 full legacy");
    busRead("R1 layout readback", 4'd0);
    chk("R1 valid bits", busRdata, 32'h070F_5337);
    for (int a = 1; a < 7; a++) busRead("R4 class after legacy", 4'(a));

    // R3: partial capability
    capMask = 32'h0000_F00F;
    busWrite(4'd0, 32'h0000_0000);
    busWrite(4'd0, 32'hFFFF_FFFF);
    settle("R3 masked write");
    busRead("R3 masked readback", 4'd0);
    chk("R3 masked value", busRdata, 32'h0000_5007);
    capMask = '1;

    // R5: class write does not reach legacy
    busWrite(4'd1, 32'h0);
    settle("R5 class clear");
    busRead("R5 legacy unchanged", 4'd0);
    busRead("R5 width limit", 4'd1);
    busWrite(4'd5, 32'hFFFF_FFFF);
    busRead("R5 timer width", 4'd5);
    chk("R5 timer read value", busRdata, 32'h0000_003F);

    // R6: legacy comparator bit keeps module in reset
    busWrite(4'd0, 32'h0200_0000);
    busWrite(4'd6, 32'h0);
    settle("R6 merge legacy only");
    chk("R6 comp held by legacy", 32'(rstComp), 32'd1);
    busWrite(4'd0, 32'h0);
    settle("R6 all clear");
    busWrite(4'd6, 32'h1);
    settle("R6 class bit only");

    // R10: extra instances only via class
    busWrite(4'd1, 32'h18);
    busWrite(4'd0, 32'h0);
    settle("R10 extra uart kept");
    chk("R10 uart3..4", 32'(rstUart), 32'h18);

    // R8: latency
    busWrite(4'd2, 32'h3);
    chk("R8 not yet", 32'(rstSsi), 32'h0);
    @(negedge clk);
    chk("R8 one edge later", 32'(rstSsi), 32'h3);

    // R7: sticky
    repeat (50) @(negedge clk);
    checkOuts("R7 hold");

    // R9: unmapped
    busWrite(4'd9, 32'hFFFF_FFFF);
    busWrite(4'd15, 32'hFFFF_FFFF);
    settle("R9 unmapped write");
    busRead("R9 unmapped read 7", 4'd7);
    busRead("R9 unmapped read 12", 4'd12);
    for (int a = 0; a < 7; a++) busRead("R9 others intact", 4'(a));

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          capMask = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
          busWrite(4'd0, $urandom);
          settle("R4 random legacy");
        end
        1: begin
          busWrite(4'(1 + $urandom % 6), $urandom);
          settle("R5 random class");
        end
        2: busRead("R1 random read", 4'($urandom % 16));
        default: settle("R7 random idle");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule